// File: doc/BRIEF.md
# DMA Interrupt Status and Mask Unit

This block collects completion events from ten DMA channels and three global conditions (transfer stall, memory FIFO empty, bus error) into one 32-bit status-and-mask word. It drives a single interrupt request line toward the processor. Each event arrives as a one-cycle pulse on its own input. The pulse sets a sticky status bit, and that bit stays set until software clears it through the register port.

Every maskable status bit has an enable bit sixteen positions above it in the same word. The interrupt is raised when any status bit meets its enable, or whenever the bus-error bit is set. The bus-error bit has no enable and cannot be masked. Software reads the whole word at once. A write clears status bits where the written data holds a one and flips enable bits where the written data holds a one. A zero in the written data leaves that bit as it is.

Top module: `dma_irq_ctrl`

## Requirements
- R1: After a synchronous reset, `rd_data` reads 0x0000_0000 and `irq` is low.
- R2: A pulse on `chan_done[i]` (i = 0..9) sets status bit i one cycle later. The bit stays set while no clearing write targets it.
- R3: A pulse on `stall_evt` sets bit 13, a pulse on `fifo_empty_evt` sets bit 14 and a pulse on `bus_err_evt` sets bit 15, each one cycle later and each sticky.
- R4: A write with data bit n = 1 (n in 0..9, 13, 14, 15) clears status bit n. A data bit of 0 leaves the status bit unchanged. If an event for the same bit arrives in the same cycle as the clearing write, the bit stays set.
- R5: A write with data bit m = 1 (m in 16..25, 29, 30) toggles enable bit m. A data bit of 0 leaves the enable bit unchanged. Enable bits change only on writes.
- R6: Bits 10..12, 26..28 and 31 always read as zero, and writing ones to them has no effect on any bit.
- R7: `irq` equals (status[15:0] AND enables[31:16] nonzero) OR status bit 15. It is evaluated on the register state and appears one cycle after that state.
- R8: The bus-error status bit raises `irq` on the following cycle whatever the enable bits hold, and no write to any enable position suppresses it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| chan_done | input | 10 | Per-channel completion pulses |
| stall_evt | input | 1 | Stall condition pulse |
| fifo_empty_evt | input | 1 | Memory FIFO empty pulse |
| bus_err_evt | input | 1 | Bus error pulse |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data: low half clears status, high half toggles enables |
| rd_data | output | 32 | Current status (low half) and enables (high half) |
| irq | output | 1 | Registered interrupt request |

## Verification
The embedded assertions check four properties on every cycle:
- A pulsed event is present in the status word on the next cycle, even when a clearing write arrives at the same time.
- Status holds while it sees neither events nor writes.
- Enables move only on writes.
- The interrupt is forced high by a pending bus error and held low when nothing is pending.

The bench's cycle model is needed for the properties that depend on exact values: the exact toggle arithmetic on enables, the reserved bits ignoring writes, and the one-cycle interrupt lag. Its directed and random scenarios cover these, including simultaneous clear-and-set and an attempt to mask the bus error.

// File: rtl/dirq_pkg.sv
package dirq_pkg;

    localparam int NUM_CH     = 10;
    localparam int HALF_W     = 16;
    localparam int WORD_W     = 2 * HALF_W;
    localparam int STALL_POS  = 13;
    localparam int FEMPTY_POS = 14;
    localparam int BUSERR_POS = 15;

    // Sticky status sources
    typedef struct packed {
        logic              buserr;
        logic              fempty;
        logic              stall;
        logic [NUM_CH-1:0] chan;
    } dirq_stat_t;

    // Enable bits (bus error has none)
    typedef struct packed {
        logic              fempty;
        logic              stall;
        logic [NUM_CH-1:0] chan;
    } dirq_en_t;

    localparam int STAT_W = $bits(dirq_stat_t);
    localparam int EN_W   = $bits(dirq_en_t);

    function automatic logic [HALF_W-1:0] stat_to_half(dirq_stat_t s);
        logic [HALF_W-1:0] h;
        h = '0;
        h[NUM_CH-1:0] = s.chan;
        h[STALL_POS]  = s.stall;
        h[FEMPTY_POS] = s.fempty;
        h[BUSERR_POS] = s.buserr;
        return h;
    endfunction

    function automatic dirq_stat_t half_to_stat(logic [HALF_W-1:0] h);
        dirq_stat_t s;
        s.chan   = h[NUM_CH-1:0];
        s.stall  = h[STALL_POS];
        s.fempty = h[FEMPTY_POS];
        s.buserr = h[BUSERR_POS];
        return s;
    endfunction

    function automatic logic [HALF_W-1:0] en_to_half(dirq_en_t e);
        logic [HALF_W-1:0] h;
        h = '0;
        h[NUM_CH-1:0] = e.chan;
        h[STALL_POS]  = e.stall;
        h[FEMPTY_POS] = e.fempty;
        return h;
    endfunction

    function automatic dirq_en_t half_to_en(logic [HALF_W-1:0] h);
        dirq_en_t e;
        e.chan   = h[NUM_CH-1:0];
        e.stall  = h[STALL_POS];
        e.fempty = h[FEMPTY_POS];
        return e;
    endfunction

endpackage

// File: rtl/dirq_sticky.sv
module dirq_sticky #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    // Set dominates clear so an event is never lost
    always_ff @(posedge clk) begin
        if (rst) q_o <= '0;
        else     q_o <= (q_o & ~clr_i) | set_i;
    end

    AST_EVT_WINS: assert property (@(posedge clk) disable iff (rst)
        (set_i != '0) |=> ((q_o & $past(set_i)) == $past(set_i))); // R4

    AST_STAT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (set_i == '0 && clr_i == '0) |=> $stable(q_o)); // R2
endmodule

// File: rtl/dirq_toggle.sv
module dirq_toggle #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] flip_i,
    output logic [W-1:0] q_o
);
    always_ff @(posedge clk) begin
        if (rst) q_o <= '0;
        else     q_o <= q_o ^ flip_i;
    end

    AST_EN_STABLE: assert property (@(posedge clk) disable iff (rst)
        (flip_i == '0) |=> $stable(q_o)); // R5
endmodule

// File: rtl/dirq_reqgen.sv
module dirq_reqgen
    import dirq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  dirq_stat_t stat_i,
    input  dirq_en_t   en_i,
    output logic       irq_o
);
    logic chan_hit, misc_hit, any_req;

    always_comb begin
        chan_hit = |(stat_i.chan & en_i.chan);
        misc_hit = (stat_i.stall & en_i.stall) | (stat_i.fempty & en_i.fempty);
        any_req  = chan_hit | misc_hit | stat_i.buserr;
    end

    always_ff @(posedge clk) begin
        if (rst) irq_o <= 1'b0;
        else     irq_o <= any_req;
    end
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
    import dirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] chan_done,
    input  logic              stall_evt,
    input  logic              fifo_empty_evt,
    input  logic              bus_err_evt,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    output logic              irq
);
    dirq_stat_t evt_set, stat_clr, stat_q;
    dirq_en_t   en_flip, en_q;

    always_comb begin
        evt_set.chan   = chan_done;
        evt_set.stall  = stall_evt;
        evt_set.fempty = fifo_empty_evt;
        evt_set.buserr = bus_err_evt;
        stat_clr = wr_en ? half_to_stat(wr_data[HALF_W-1:0])      : '0;
        en_flip  = wr_en ? half_to_en(wr_data[WORD_W-1:HALF_W])   : '0;
    end

    dirq_sticky #(.W(STAT_W)) u_stat (
        .clk  (clk),
        .rst  (rst),
        .set_i(evt_set),
        .clr_i(stat_clr),
        .q_o  (stat_q)
    );

    dirq_toggle #(.W(EN_W)) u_en (
        .clk   (clk),
        .rst   (rst),
        .flip_i(en_flip),
        .q_o   (en_q)
    );

    dirq_reqgen u_req (
        .clk   (clk),
        .rst   (rst),
        .stat_i(stat_q),
        .en_i  (en_q),
        .irq_o (irq)
    );

    assign rd_data = {en_to_half(en_q), stat_to_half(stat_q)};

    AST_BUSERR_IRQ: assert property (@(posedge clk) disable iff (rst)
        rd_data[BUSERR_POS] |=> irq); // R8

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        (((rd_data[HALF_W-1:0] & rd_data[WORD_W-1:HALF_W]) == '0) && !rd_data[BUSERR_POS])
        |=> !irq); // R7
endmodule

// File: tb/dma_irq_ctrl_test.sv
module dma_irq_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] STAT_VALID = 32'h0000_E3FF;
    localparam logic [31:0] EN_VALID   = 32'h63FF_0000;
    localparam logic [31:0] RSV_BITS   = 32'h9C00_1C00;

    logic        clk = 0;
    logic        rst = 1;
    logic [9:0]  chan_done = '0;
    logic        stall_evt = 0, fifo_empty_evt = 0, bus_err_evt = 0;
    logic        wr_en = 0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_irq_ctrl uut (
        .clk(clk), .rst(rst), .chan_done(chan_done), .stall_evt(stall_evt),
        .fifo_empty_evt(fifo_empty_evt), .bus_err_evt(bus_err_evt),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    // Behavioural reference model
    logic [31:0] m_word = '0;
    logic        m_irq  = 0;

    always @(posedge clk) begin
        logic [31:0] evw, nw;
        if (rst) begin
            m_word <= '0;
            m_irq  <= 0;
        end else begin
            evw = {16'h0, bus_err_evt, fifo_empty_evt, stall_evt, 3'b000, chan_done};
            nw  = m_word;
            if (wr_en) begin
                nw = nw & ~(wr_data & STAT_VALID);
                nw = nw ^ (wr_data & EN_VALID);
            end
            nw = nw | evw;
            m_irq  <= ((m_word[15:0] & m_word[31:16]) != 0) || m_word[15];
            m_word <= nw;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Per-cycle comparison away from the active edge
    bit run_cmp = 0;
    always @(negedge clk) begin
        if (run_cmp && !rst) begin
            chk((rd_data & STAT_VALID) == (m_word & STAT_VALID), "R2 status", rd_data, m_word);
            chk((rd_data & EN_VALID) == (m_word & EN_VALID), "R5 enables", rd_data, m_word);
            chk((rd_data & RSV_BITS) == 0, "R6 reserved", rd_data, 32'h0);
            chk(irq == m_irq, "R7 irq", {31'h0, irq}, {31'h0, m_irq});
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        chan_done = '0; stall_evt = 0; fifo_empty_evt = 0; bus_err_evt = 0;
        wr_en = 0; wr_data = '0;
    endtask

    task automatic wr(input logic [31:0] d);
        wr_en = 1; wr_data = d;
        tick();
    endtask

    bit done = 0;
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'h0, 32'h1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk); @(negedge clk);
        rst = 0;
        chk(rd_data == 32'h0, "R1 reset word", rd_data, 32'h0);
        chk(irq == 1'b0, "R1 reset irq", {31'h0, irq}, 32'h0);
        run_cmp = 1;

        // R2: channel 3 and 9 pulses, sticky
        chan_done = 10'h208; tick();
        chk(rd_data == 32'h0000_0208, "R2 chan set", rd_data, 32'h208);
        tick(); tick();
        chk(rd_data == 32'h0000_0208, "R2 chan sticky", rd_data, 32'h208);
        chk(irq == 0, "R7 no enable no irq", {31'h0, irq}, 32'h0);

        // R3: stall and fifo-empty bits
        stall_evt = 1; fifo_empty_evt = 1; tick();
        chk(rd_data == 32'h0000_6208, "R3 stall/fifo", rd_data, 32'h6208);

        // R5/R7: enable ch3 -> irq two edges later
        wr(32'h0008_0000);
        chk(rd_data == 32'h0008_6208, "R5 enable toggle on", rd_data, 32'h0008_6208);
        chk(irq == 0, "R7 irq lag", {31'h0, irq}, 32'h0);
        tick();
        chk(irq == 1, "R7 irq raised", {31'h0, irq}, 32'h1);

        // R4: clear ch3 with simultaneous ch3 event -> stays
        chan_done = 10'h008; wr_en = 1; wr_data = 32'h0000_0008; tick();
        chk(rd_data[3] == 1, "R4 event wins", rd_data, 32'h0008_6208);
        wr(32'h0000_0008);
        chk(rd_data == 32'h0008_6200, "R4 clear", rd_data, 32'h0008_6200);
        tick();
        chk(irq == 0, "R7 irq dropped", {31'h0, irq}, 32'h0);

        // R5: toggle off again
        wr(32'h0008_0000);
        chk(rd_data == 32'h0000_6200, "R5 enable toggle off", rd_data, 32'h6200);

        // R6: reserved writes ignored
        wr(RSV_BITS);
        chk(rd_data == 32'h0000_6200, "R6 reserved write", rd_data, 32'h6200);

        // R8: bus error unmaskable
        bus_err_evt = 1; tick();
        chk(rd_data[15] == 1, "R3 bus error bit", rd_data, 32'h0000_E200);
        wr(32'h8000_0000);
        chk(irq == 1, "R8 bus error irq", {31'h0, irq}, 32'h1);
        tick();
        chk(irq == 1, "R8 still high", {31'h0, irq}, 32'h1);
        wr(32'h0000_FFFF);
        tick();
        chk(rd_data == 32'h0 && irq == 0, "R4 clear all", rd_data, 32'h0);

        // Random phase checked by the cycle model
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(3) == 0) chan_done = 10'($urandom);
            stall_evt      = ($urandom_range(7) == 0);
            fifo_empty_evt = ($urandom_range(7) == 0);
            bus_err_evt    = ($urandom_range(31) == 0);
            wr_en   = ($urandom_range(2) == 0);
            wr_data = $urandom;
            tick();
        end

        rst = 1; tick(); rst = 0;
        chk(rd_data == 32'h0 && irq == 0, "R1 re-reset", rd_data, 32'h0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule